// File: doc/BRIEF.md
# Banked Data Register File with Shared Global Window

This block holds the 8-bit data registers of a small microcontroller core. An instruction names a register with a 5-bit direct address. A file select register (FSR) is held inside the block. Its three upper bits pick one of eight 16-byte banks, and the upper half of the address space resolves into whichever bank is selected. The lower half is shared by all banks:

- Eight global general-purpose bytes appear identically in every bank.
- Eight dedicated slots appear identically in every bank. One of them is the FSR itself. The other seven are handed to neighbouring logic through a slot-select and strobe interface.

The core reads through a combinational port and writes through a clocked port. The FSR can be changed in three ways:

- a full-byte load on a dedicated FSR port;
- an ordinary register write to the FSR slot;
- a bank operation that rewrites only the three bank bits.

Top module: `banked_regfile`

## Requirements
- R1: While `rstN` is low, and after it is released, the FSR reads as 00h (bank 0 selected) and every stored byte reads as 00h.
- R2: Addresses 10h–1Fh are banked. The storage index is {FSR[7:5], addr[3:0]}, so the same address in different banks reaches different bytes.
- R3: Addresses 08h–0Fh are global. A value written there reads back the same whatever bank is selected.
- R4: Address 04h is the FSR. A read returns all 8 FSR bits, and a write loads all 8 bits.
- R5: `fsrWrEn` loads `fsrWrData` into all 8 FSR bits at the next rising edge.
- R6: `bankWrEn` loads `bankWrVal` into FSR[7:5] and leaves FSR[4:0] unchanged.
- R7: In the same cycle, `fsrWrEn` takes precedence over a write to address 04h. If `bankWrEn` is also asserted in that cycle, it then overrides FSR[7:5] of whichever byte was loaded.
- R8: Addresses 00h–03h and 05h–07h are external dedicated slots.
  - A read of such a slot returns `extRdData`, raises `extRdActive` and presents addr[2:0] on `extRdSlot`.
  - A write to such a slot raises `extWrStb` with addr[2:0] on `extWrSlot` and changes no stored byte.
- R9: Reads are combinational from `rdAddr` and the current FSR. Writes take effect at the rising clock edge. A banked write uses the FSR value held before that edge.
- R10: `extRdActive` is low for any read address outside the external dedicated slots. `extWrStb` is low unless `wrEn` targets an external dedicated slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| rdAddr | input | 5 | Direct read address |
| rdData | output | 8 | Combinational read data |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 5 | Direct write address |
| wrData | input | 8 | Register write data |
| fsrWrEn | input | 1 | Full-byte FSR load |
| fsrWrData | input | 8 | FSR load value |
| bankWrEn | input | 1 | Bank-only FSR update |
| bankWrVal | input | 3 | New bank number |
| extRdData | input | 8 | Read data from external dedicated slots |
| extRdActive | output | 1 | Read targets an external dedicated slot |
| extRdSlot | output | 3 | External slot being read |
| extWrStb | output | 1 | Write strobe for an external dedicated slot |
| extWrSlot | output | 3 | External slot being written |

## Verification
Read data and the external select outputs are combinational. The bench therefore samples them 1 ns after it drives inputs at the falling edge, in the same cycle as the stimulus. Writes, FSR loads and bank operations land at the next rising edge. The bench updates its reference model immediately after that edge and checks the effect with the read issued in the following cycle. A write and a read that share a cycle are therefore compared against pre-edge state, which is what exposes a banked write that wrongly uses the new bank.

// File: rtl/brf_pkg.sv
package brf_pkg;

  typedef enum logic [1:0] {
    RD_BANKED = 2'd0,
    RD_GLOBAL = 2'd1,
    RD_FSR    = 2'd2,
    RD_EXT    = 2'd3
  } rdSrc_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   globWr;
    logic   bankedWr;
    logic   fsrBusWr;
    logic   fsrByteWr;
    logic   fsrBankWr;
    logic   extWr;
    rdSrc_e rdSrc;
  } strobes_t;

endpackage

// File: rtl/brf_ctrl.sv
module brf_ctrl
  import brf_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int FSR_SLOT = 4,
  localparam int SLOT_W  = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              fsrWrEn,
  input  logic              bankWrEn,
  output strobes_t          stb,
  output logic              extRdActive,
  output logic [SLOT_W-1:0] extRdSlot,
  output logic              extWrStb,
  output logic [SLOT_W-1:0] extWrSlot
);

  logic wrBanked, wrGlobal, wrFsr;
  logic rdBanked, rdGlobal, rdFsr;

  always_comb begin
    wrBanked = wrAddr[ADDR_W-1];
    wrGlobal = !wrAddr[ADDR_W-1] && wrAddr[ADDR_W-2];
    wrFsr    = (wrAddr == ADDR_W'(FSR_SLOT));
    rdBanked = rdAddr[ADDR_W-1];
    rdGlobal = !rdAddr[ADDR_W-1] && rdAddr[ADDR_W-2];
    rdFsr    = (rdAddr == ADDR_W'(FSR_SLOT));
  end

  always_comb begin
    stb           = '0;
    stb.globWr    = wrEn && wrGlobal;
    stb.bankedWr  = wrEn && wrBanked;
    stb.fsrBusWr  = wrEn && wrFsr && !fsrWrEn;
    stb.fsrByteWr = fsrWrEn;
    stb.fsrBankWr = bankWrEn;
    stb.extWr     = wrEn && !wrBanked && !wrGlobal && !wrFsr;
    if (rdBanked)      stb.rdSrc = RD_BANKED;
    else if (rdGlobal) stb.rdSrc = RD_GLOBAL;
    else if (rdFsr)    stb.rdSrc = RD_FSR;
    else               stb.rdSrc = RD_EXT;
  end

  assign extRdActive = (stb.rdSrc == RD_EXT);
  assign extRdSlot   = rdAddr[SLOT_W-1:0];
  assign extWrStb    = stb.extWr;
  assign extWrSlot   = wrAddr[SLOT_W-1:0];

  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.globWr, stb.bankedWr, stb.fsrBusWr, stb.extWr})); // R8

  AST_EXT_WR_IN_LOW_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    extWrStb |-> (wrAddr[ADDR_W-1 -: 2] == 2'b00)); // R10

  AST_EXT_RD_NOT_FSR: assert property (@(posedge clk) disable iff (!rstN)
    extRdActive |-> (rdAddr != ADDR_W'(FSR_SLOT))); // R8

endmodule

// File: rtl/brf_datapath.sv
module brf_datapath
  import brf_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 5,
  parameter int BANK_W  = 3,
  localparam int OFFS_W = ADDR_W - 1,
  localparam int SLOT_W = ADDR_W - 2,
  localparam int GLOB_N = 1 << SLOT_W,
  localparam int BANK_N = 1 << (BANK_W + OFFS_W),
  localparam int LOW_W  = DATA_W - BANK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] fsrWrData,
  input  logic [BANK_W-1:0] bankWrVal,
  input  logic [DATA_W-1:0] extRdData,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] fsrQ, fsrNext;
  logic [DATA_W-1:0] globMem [GLOB_N];
  logic [DATA_W-1:0] bankMem [BANK_N];
  logic [BANK_W-1:0] curBank;
  logic [BANK_W+OFFS_W-1:0] wrBankIdx, rdBankIdx;

  assign curBank   = fsrQ[DATA_W-1 -: BANK_W];
  assign wrBankIdx = {curBank, wrAddr[OFFS_W-1:0]};
  assign rdBankIdx = {curBank, rdAddr[OFFS_W-1:0]};

  always_comb begin
    fsrNext = fsrQ;
    if (stb.fsrByteWr)     fsrNext = fsrWrData;
    else if (stb.fsrBusWr) fsrNext = wrData;
    if (stb.fsrBankWr)     fsrNext[DATA_W-1 -: BANK_W] = bankWrVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fsrQ <= '0;
    else       fsrQ <= fsrNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < GLOB_N; i++) globMem[i] <= '0;
    end else if (stb.globWr) begin
      globMem[wrAddr[SLOT_W-1:0]] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BANK_N; i++) bankMem[i] <= '0;
    end else if (stb.bankedWr) begin
      bankMem[wrBankIdx] <= wrData;
    end
  end

  always_comb begin
    case (stb.rdSrc)
      RD_BANKED: rdData = bankMem[rdBankIdx];
      RD_GLOBAL: rdData = globMem[rdAddr[SLOT_W-1:0]];
      RD_FSR:    rdData = fsrQ;
      default:   rdData = extRdData;
    endcase
  end

  AST_RESET_BANK0: assert property (@(posedge clk)
    !rstN |=> (fsrQ == '0)); // R1

  AST_FULL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (stb.fsrByteWr && !stb.fsrBankWr) |=> (fsrQ == $past(fsrWrData))); // R5

  AST_BANK_OP_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (stb.fsrBankWr && !stb.fsrByteWr && !stb.fsrBusWr)
      |=> (fsrQ[LOW_W-1:0] == $past(fsrQ[LOW_W-1:0]))); // R6

  AST_BANK_OP_WINS: assert property (@(posedge clk) disable iff (!rstN)
    stb.fsrBankWr |=> (fsrQ[DATA_W-1 -: BANK_W] == $past(bankWrVal))); // R7

  AST_FSR_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.fsrByteWr || stb.fsrBusWr || stb.fsrBankWr) |=> $stable(fsrQ)); // R9

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import brf_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 5,
  parameter int BANK_W   = 3,
  parameter int FSR_SLOT = 4,
  localparam int SLOT_W  = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              fsrWrEn,
  input  logic [DATA_W-1:0] fsrWrData,
  input  logic              bankWrEn,
  input  logic [BANK_W-1:0] bankWrVal,
  input  logic [DATA_W-1:0] extRdData,
  output logic              extRdActive,
  output logic [SLOT_W-1:0] extRdSlot,
  output logic              extWrStb,
  output logic [SLOT_W-1:0] extWrSlot
);

  strobes_t stb;

  brf_ctrl #(.ADDR_W(ADDR_W), .FSR_SLOT(FSR_SLOT)) u_ctrl (
    .clk(clk), .rstN(rstN), .rdAddr(rdAddr), .wrEn(wrEn), .wrAddr(wrAddr),
    .fsrWrEn(fsrWrEn), .bankWrEn(bankWrEn), .stb(stb),
    .extRdActive(extRdActive), .extRdSlot(extRdSlot),
    .extWrStb(extWrStb), .extWrSlot(extWrSlot)
  );

  brf_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdAddr(rdAddr), .wrAddr(wrAddr),
    .wrData(wrData), .fsrWrData(fsrWrData), .bankWrVal(bankWrVal),
    .extRdData(extRdData), .rdData(rdData)
  );

endmodule

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;
  localparam int PERIOD = 10;

  logic clk = 0, rstN = 0;
  logic [4:0] rdAddr = 0, wrAddr = 0;
  logic [7:0] rdData, wrData = 0, fsrWrData = 0, extRdData = 0;
  logic wrEn = 0, fsrWrEn = 0, bankWrEn = 0;
  logic [2:0] bankWrVal = 0, extRdSlot, extWrSlot;
  logic extRdActive, extWrStb;

  int vectors = 0, fails = 0;
  bit done = 0;
  logic [7:0] refFsr;
  logic [7:0] refGlob [8];
  logic [7:0] refBank [128];

  always #(PERIOD/2) clk = ~clk;

  banked_regfile u_banked_regfile (
    .clk(clk), .rstN(rstN), .rdAddr(rdAddr), .rdData(rdData), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .fsrWrEn(fsrWrEn), .fsrWrData(fsrWrData),
    .bankWrEn(bankWrEn), .bankWrVal(bankWrVal), .extRdData(extRdData),
    .extRdActive(extRdActive), .extRdSlot(extRdSlot),
    .extWrStb(extWrStb), .extWrSlot(extWrSlot)
  );

  function automatic bit isExt(input logic [4:0] a);
    return (a[4:3] == 2'b00) && (a != 5'd4);
  endfunction

  function automatic logic [7:0] expRead(input logic [4:0] a);
    if (a[4])       return refBank[{refFsr[7:5], a[3:0]}];
    else if (a[3])  return refGlob[a[2:0]];
    else if (a == 5'd4) return refFsr;
    else            return extRdData;
  endfunction

  function automatic string reqOf(input logic [4:0] a);
    if (a[4]) return "R2";
    else if (a[3]) return "R3";
    else if (a == 5'd4) return "R4";
    else return "R8";
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive at falling edge, check comb outputs, apply model at rising edge
  task automatic step(input logic wE, input logic [4:0] wA, input logic [7:0] wD,
                      input logic fE, input logic [7:0] fD,
                      input logic bE, input logic [2:0] bV, input logic [4:0] rA);
    logic [7:0] nf;
    @(negedge clk);
    wrEn = wE; wrAddr = wA; wrData = wD;
    fsrWrEn = fE; fsrWrData = fD; bankWrEn = bE; bankWrVal = bV;
    rdAddr = rA; extRdData = 8'($urandom);
    #1;
    chk({reqOf(rA), "/R9"}, rdData, expRead(rA));
    chk("R10 extRdActive", {7'd0, extRdActive}, {7'd0, isExt(rA)});
    if (isExt(rA)) chk("R8 extRdSlot", {5'd0, extRdSlot}, {5'd0, rA[2:0]});
    chk("R10 extWrStb", {7'd0, extWrStb}, {7'd0, wE && isExt(wA)});
    if (wE && isExt(wA)) chk("R8 extWrSlot", {5'd0, extWrSlot}, {5'd0, wA[2:0]});
    @(posedge clk);
    nf = refFsr;
    if (wE && wA[4]) refBank[{refFsr[7:5], wA[3:0]}] = wD;
    if (wE && !wA[4] && wA[3]) refGlob[wA[2:0]] = wD;
    if (fE) nf = fD;
    else if (wE && wA == 5'd4) nf = wD;
    if (bE) nf[7:5] = bV;
    refFsr = nf;
  endtask

  task automatic idleRead(input logic [4:0] rA);
    step(0, 0, 0, 0, 0, 0, 0, rA);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    refFsr = 0;
    for (int i = 0; i < 8; i++) refGlob[i] = 0;
    for (int i = 0; i < 128; i++) refBank[i] = 0;
    rdAddr = 5'd4;
    #(PERIOD * 3 + 1);
    chk("R1 fsr in reset", rdData, 8'h00);
    rstN = 1;
    idleRead(5'd4);                                  // R1 bank 0 after reset
    idleRead(5'h15);                                 // R1 banked byte zero
    idleRead(5'h0B);                                 // R1 global byte zero
    // R3: global visible from another bank
    step(1, 5'h0A, 8'hA5, 0, 0, 0, 0, 5'h0A);
    step(0, 0, 0, 0, 0, 1, 3'd5, 5'h0A);
    idleRead(5'h0A);
    // R2: same address, separate banks
    step(1, 5'h12, 8'h51, 0, 0, 0, 0, 5'h12);
    step(0, 0, 0, 0, 0, 1, 3'd2, 5'h12);
    step(1, 5'h12, 8'h22, 0, 0, 0, 0, 5'h12);
    step(0, 0, 0, 0, 0, 1, 3'd5, 5'h12);
    // R9: banked write in same cycle as bank switch uses old bank
    step(1, 5'h1F, 8'h77, 0, 0, 1, 3'd6, 5'h1F);
    idleRead(5'h1F);
    step(0, 0, 0, 0, 0, 1, 3'd5, 5'h1F);
    // R5, R6: full load then bank op keeps low bits
    step(0, 0, 0, 1, 8'h1F, 0, 0, 5'd4);
    step(0, 0, 0, 0, 0, 1, 3'd3, 5'd4);
    idleRead(5'd4);
    // R4: direct write of FSR slot
    step(1, 5'd4, 8'hC9, 0, 0, 0, 0, 5'd4);
    idleRead(5'd4);
    // R7: priorities
    step(1, 5'd4, 8'h11, 1, 8'h2E, 0, 0, 5'd4);
    idleRead(5'd4);
    step(1, 5'd4, 8'h0D, 1, 8'hE3, 1, 3'd1, 5'd4);
    idleRead(5'd4);
    step(1, 5'd4, 8'hF0, 0, 0, 1, 3'd4, 5'd4);
    idleRead(5'd4);
    // R8: external slot write leaves storage alone
    step(1, 5'd2, 8'hEE, 0, 0, 0, 0, 5'd7);
    idleRead(5'd2);
    idleRead(5'h0A);
    // Random mix
    for (int n = 0; n < 4000; n++) begin
      step($urandom_range(0, 2) != 0, 5'($urandom), 8'($urandom),
           $urandom_range(0, 9) == 0, 8'($urandom),
           $urandom_range(0, 5) == 0, 3'($urandom), 5'($urandom));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule